// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block puts an index/data pair of configuration ports on an 8-bit I/O bus. Its registers are reachable only after an unlock key has been written, and another key locks them again. The 16-bit address of the index port is chosen by two strap inputs. The block captures those straps while reset is held, and keeps the captured value once reset is released. The data port sits at the index port address plus one.

While unlocked, a byte written to the index port selects one internal register. Accesses to the data port then read or write the selected register. The registers hold the following, and the block drives each field straight out as a port for neighbouring logic:

- power enables, I/O bases and IRQ numbers for two serial ports;
- a relocatable base and an address-decode enable for a runtime register block;
- direction, inversion and output-type settings for two groups of eight GPIO pins.

Top module: `cfgport_ctrl`

## Requirements
- R1: All configuration registers and all exported fields are 0 after reset, and the block starts locked.
- R2: The index port address comes from the captured straps {strap[1],strap[0]}: 0 selects 0x002E, 1 selects 0x004E, 2 selects 0x162E and 3 selects 0x164E. The data port is the index port address + 1. The straps are captured while rst_n is low and are held once rst_n is high.
- R3: Writing 0x55 to the index port while locked unlocks the block, and the change takes effect at that clock edge. Writing 0xAA to the index port while unlocked locks it again.
- R4: While locked, data port writes are ignored, data port reads return 0x00, and any byte other than 0x55 written to the index port has no effect.
- R5: While unlocked, any byte other than 0xAA written to the index port becomes the register index. A data port write updates the indexed register at the clock edge. A data port read returns the indexed register on io_rdata in the same cycle, and io_rdata is 0x00 at all other times.
- R6: Register 0x02 bit 3 drives ser_pwr[0] and bit 7 drives ser_pwr[1].
- R7: Registers 0x24 and 0x25 give the bases of serial ports 1 and 2. Register bits 7:1 become address bits 9:3, and the low three address bits are 0.
- R8: Register 0x28 gives ser1_irq in bits 7:4 and ser2_irq in bits 3:0.
- R9: rt_base is {reg 0x21 bits 3:0, reg 0x30, 4'h0}. Register 0x3A bit 1 drives rt_en.
- R10: GPIO group 0 (pins 7:0) uses register 0x31 for direction, 0x32 for inversion and 0x33 for open-drain type. Group 1 (pins 15:8) uses 0x35, 0x36 and 0x37 for the same settings.
- R11: Indices outside the implemented set read as 0x00, and writes to them change nothing.
- R12: Accesses to any address other than the index port and the data port have no effect and read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are captured while it is low |
| strap | input | 2 | Base port select straps |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, valid while io_rd is high |
| ser_pwr | output | 2 | Serial port power enables (bit 0 port 1, bit 1 port 2) |
| ser1_base | output | 10 | Serial port 1 I/O base |
| ser2_base | output | 10 | Serial port 2 I/O base |
| ser1_irq | output | 4 | Serial port 1 IRQ number |
| ser2_irq | output | 4 | Serial port 2 IRQ number |
| rt_base | output | 16 | Runtime block I/O base |
| rt_en | output | 1 | Runtime block decode enable |
| gpio_dir | output | 16 | GPIO direction, 1 = output |
| gpio_inv | output | 16 | GPIO polarity invert |
| gpio_od | output | 16 | GPIO open-drain select |

## Verification
The checks assume that io_wr and io_rd are never high in the same cycle, that each write strobe lasts one clock, and that the straps are steady during the last reset cycle. They also assume that the consumer of read data samples io_rdata while io_rd is still high. The directed stimulus changes the bus only on the falling clock edge and performs one access at a time. It changes the straps only while reset is held, and it samples read data a short delay after raising io_rd, before the next rising edge.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   localparam int          BYTE_W      = 8;
   localparam int          GPIO_GRP    = 2;
   localparam int          GPIO_PER    = 8;
   localparam logic [7:0]  KEY_OPEN    = 8'h55;
   localparam logic [7:0]  KEY_CLOSE   = 8'hAA;

   // storage slots, in slot order
   localparam int          NREG        = 13;
   localparam int          S_PWR       = 0;
   localparam int          S_RTHI      = 1;
   localparam int          S_SER1      = 2;
   localparam int          S_SER2      = 3;
   localparam int          S_IRQ       = 4;
   localparam int          S_RTLO      = 5;
   localparam int          S_GPIO0     = 6;   // dir, inv, od follow; next group +3
   localparam int          S_ACT       = 12;

   localparam logic [7:0]  SLOT_IDX [NREG] = '{
      8'h02, 8'h21, 8'h24, 8'h25, 8'h28, 8'h30,
      8'h31, 8'h32, 8'h33, 8'h35, 8'h36, 8'h37, 8'h3A };

   function automatic logic [15:0] port_of(input logic [1:0] sel);
      port_of = {(sel[1] ? 8'h16 : 8'h00), (sel[0] ? 8'h4E : 8'h2E)};
   endfunction
endpackage

// File: rtl/cfgport_keylock.sv
module cfgport_keylock
   import cfgport_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          strap,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic                io_wr,
   input  logic [BYTE_W-1:0]   io_wdata,
   output logic [ADDR_W-1:0]   base_port,
   output logic                idx_hit,
   output logic                dat_hit,
   output logic                cfg_mode,
   output logic [BYTE_W-1:0]   index
);
   logic [1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= strap;
   end

   assign base_port = ADDR_W'(port_of(sel_q));
   assign idx_hit   = (io_addr == base_port);
   assign dat_hit   = (io_addr == base_port + ADDR_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_mode <= 1'b0;
         index    <= '0;
      end else if (io_wr && idx_hit) begin
         if (!cfg_mode) begin
            if (io_wdata == KEY_OPEN) cfg_mode <= 1'b1;
         end else if (io_wdata == KEY_CLOSE) begin
            cfg_mode <= 1'b0;
         end else begin
            index <= io_wdata;
         end
      end
   end
endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
   import cfgport_pkg::*;
(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [BYTE_W-1:0]             index,
   input  logic [BYTE_W-1:0]             wdata,
   output logic [NREG-1:0][BYTE_W-1:0]   q,
   output logic [BYTE_W-1:0]             rd_data
);
   logic [NREG-1:0] hit;

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      assign hit[i] = (index == SLOT_IDX[i]);
      always_ff @(posedge clk) begin
         if (!rst_n)               q[i] <= '0;
         else if (wr_en && hit[i]) q[i] <= wdata;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++)
         if (hit[i]) rd_data = rd_data | q[i];
   end
endmodule

// File: rtl/cfgport_fields.sv
module cfgport_fields
   import cfgport_pkg::*;
(
   input  logic [NREG-1:0][BYTE_W-1:0]        q,
   output logic [1:0]                         ser_pwr,
   output logic [9:0]                         ser1_base,
   output logic [9:0]                         ser2_base,
   output logic [3:0]                         ser1_irq,
   output logic [3:0]                         ser2_irq,
   output logic [15:0]                        rt_base,
   output logic                               rt_en,
   output logic [GPIO_GRP*GPIO_PER-1:0]       gpio_dir,
   output logic [GPIO_GRP*GPIO_PER-1:0]       gpio_inv,
   output logic [GPIO_GRP*GPIO_PER-1:0]       gpio_od
);
   assign ser_pwr   = {q[S_PWR][7], q[S_PWR][3]};
   assign ser1_base = {q[S_SER1][7:1], 3'b000};
   assign ser2_base = {q[S_SER2][7:1], 3'b000};
   assign ser1_irq  = q[S_IRQ][7:4];
   assign ser2_irq  = q[S_IRQ][3:0];
   assign rt_base   = {q[S_RTHI][3:0], q[S_RTLO], 4'h0};
   assign rt_en     = q[S_ACT][1];

   for (genvar g = 0; g < GPIO_GRP; g++) begin : g_grp
      assign gpio_dir[g*GPIO_PER +: GPIO_PER] = q[S_GPIO0 + 3*g];
      assign gpio_inv[g*GPIO_PER +: GPIO_PER] = q[S_GPIO0 + 3*g + 1];
      assign gpio_od [g*GPIO_PER +: GPIO_PER] = q[S_GPIO0 + 3*g + 2];
   end
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
   import cfgport_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    strap,
   input  logic [ADDR_W-1:0]             io_addr,
   input  logic                          io_wr,
   input  logic                          io_rd,
   input  logic [BYTE_W-1:0]             io_wdata,
   output logic [BYTE_W-1:0]             io_rdata,
   output logic [1:0]                    ser_pwr,
   output logic [9:0]                    ser1_base,
   output logic [9:0]                    ser2_base,
   output logic [3:0]                    ser1_irq,
   output logic [3:0]                    ser2_irq,
   output logic [15:0]                   rt_base,
   output logic                          rt_en,
   output logic [GPIO_GRP*GPIO_PER-1:0]  gpio_dir,
   output logic [GPIO_GRP*GPIO_PER-1:0]  gpio_inv,
   output logic [GPIO_GRP*GPIO_PER-1:0]  gpio_od
);
   if (ADDR_W < 13) begin : g_bad_width
      $error("cfgport_ctrl: ADDR_W must cover the highest base port");
   end
   if (GPIO_PER != BYTE_W) begin : g_bad_gpio
      $error("cfgport_ctrl: one GPIO group must fill one register");
   end

   logic [ADDR_W-1:0]           base_port;
   logic                        idx_hit, dat_hit, cfg_mode;
   logic [BYTE_W-1:0]           index, rd_data;
   logic [NREG-1:0][BYTE_W-1:0] q;

   cfgport_keylock #(.ADDR_W(ADDR_W)) u_lock (
      .clk, .rst_n, .strap, .io_addr, .io_wr, .io_wdata,
      .base_port, .idx_hit, .dat_hit, .cfg_mode, .index
   );

   cfgport_regs u_regs (
      .clk, .rst_n,
      .wr_en  (cfg_mode && io_wr && dat_hit),
      .index,
      .wdata  (io_wdata),
      .q,
      .rd_data
   );

   cfgport_fields u_fields (
      .q, .ser_pwr, .ser1_base, .ser2_base, .ser1_irq, .ser2_irq,
      .rt_base, .rt_en, .gpio_dir, .gpio_inv, .gpio_od
   );

   assign io_rdata = (cfg_mode && io_rd && dat_hit) ? rd_data : '0;
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              cfg_mode,
   input logic [ADDR_W-1:0] base_port,
   input logic [1:0]        ser_pwr,
   input logic [15:0]       gpio_dir,
   input logic [15:0]       rt_base,
   input logic              rt_en
);
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (!cfg_mode && ser_pwr == 2'b00 && gpio_dir == 16'h0
                  && rt_base == 16'h0 && !rt_en));

   a_r2_port_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(base_port));

   a_r3_unlock_key: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && io_wr && io_addr == base_port && io_wdata == 8'h55)
      |=> cfg_mode);

   a_r3_relock_key: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && io_wr && io_addr == base_port && io_wdata == 8'hAA)
      |=> !cfg_mode);

   a_r4_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && io_rd) |-> io_rdata == 8'h00);

   a_r4_locked_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |=> ($stable(ser_pwr) && $stable(gpio_dir)
                     && $stable(rt_base) && $stable(rt_en)));
endmodule

bind cfgport_ctrl cfgport_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_addr   (io_addr),
   .io_wr     (io_wr),
   .io_rd     (io_rd),
   .io_wdata  (io_wdata),
   .io_rdata  (io_rdata),
   .cfg_mode  (cfg_mode),
   .base_port (base_port),
   .ser_pwr   (ser_pwr),
   .gpio_dir  (gpio_dir),
   .rt_base   (rt_base),
   .rt_en     (rt_en)
);

// File: tb/cfgport_ctrl_test.sv
`timescale 1ns/1ps
module cfgport_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  strap = 2'b00;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [1:0]  ser_pwr;
   logic [9:0]  ser1_base, ser2_base;
   logic [3:0]  ser1_irq, ser2_irq;
   logic [15:0] rt_base, gpio_dir, gpio_inv, gpio_od;
   logic        rt_en;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   cfgport_ctrl uut (
      .clk, .rst_n, .strap, .io_addr, .io_wr, .io_rd, .io_wdata, .io_rdata,
      .ser_pwr, .ser1_base, .ser2_base, .ser1_irq, .ser2_irq,
      .rt_base, .rt_en, .gpio_dir, .gpio_inv, .gpio_od
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] s);
      @(negedge clk);
      rst_n = 1'b0;
      strap = s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      strap = ~s;           // later changes must not matter
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic set_reg(input logic [15:0] p, input logic [7:0] idx, input logic [7:0] d);
      wr(p, idx);
      wr(p + 16'd1, d);
   endtask

   task automatic t_reset_state;
      logic [7:0] d;
      do_reset(2'b00);
      chk("R1 ser_pwr", 32'(ser_pwr), 0);
      chk("R1 gpio_dir", 32'(gpio_dir), 0);
      chk("R1 rt_base/en", {rt_base, 15'b0, rt_en}, 0);
      rd(16'h002F, d);
      chk("R1 locked read", 32'(d), 0);
   endtask

   task automatic t_locked_ignore;
      logic [7:0] d;
      wr(16'h002F, 8'hFF);
      chk("R4 data write while locked", 32'(ser_pwr), 0);
      wr(16'h002E, 8'h02);
      wr(16'h002F, 8'h88);
      chk("R4 non-key byte keeps lock", 32'(ser_pwr), 0);
      rd(16'h002F, d);
      chk("R4 read while locked", 32'(d), 0);
   endtask

   task automatic t_power;
      logic [7:0] d;
      wr(16'h002E, 8'h55);
      set_reg(16'h002E, 8'h02, 8'h88);
      chk("R6 both ports powered", 32'(ser_pwr), 32'h3);
      rd(16'h002F, d);
      chk("R5 readback", 32'(d), 32'h88);
      wr(16'h002F, 8'h08);
      chk("R6 port1 only", 32'(ser_pwr), 32'h1);
   endtask

   task automatic t_serial;
      set_reg(16'h002E, 8'h24, 8'hFE);
      set_reg(16'h002E, 8'h25, 8'hBE);
      chk("R7 ser1_base", 32'(ser1_base), 32'h3F8);
      chk("R7 ser2_base", 32'(ser2_base), 32'h2F8);
      set_reg(16'h002E, 8'h28, 8'h43);
      chk("R8 irqs", {ser1_irq, ser2_irq}, 32'h43);
   endtask

   task automatic t_runtime;
      set_reg(16'h002E, 8'h30, 8'h68);
      set_reg(16'h002E, 8'h21, 8'h0A);
      chk("R9 rt_base", 32'(rt_base), 32'hA680);
      chk("R9 rt_en off", 32'(rt_en), 0);
      set_reg(16'h002E, 8'h3A, 8'h02);
      chk("R9 rt_en on", 32'(rt_en), 1);
   endtask

   task automatic t_gpio;
      set_reg(16'h002E, 8'h31, 8'hA5);
      set_reg(16'h002E, 8'h35, 8'h3C);
      set_reg(16'h002E, 8'h32, 8'h0F);
      set_reg(16'h002E, 8'h36, 8'hF0);
      set_reg(16'h002E, 8'h33, 8'h81);
      set_reg(16'h002E, 8'h37, 8'h18);
      chk("R10 gpio_dir", 32'(gpio_dir), 32'h3CA5);
      chk("R10 gpio_inv", 32'(gpio_inv), 32'hF00F);
      chk("R10 gpio_od", 32'(gpio_od), 32'h1881);
   endtask

   task automatic t_unimpl;
      logic [7:0] d;
      set_reg(16'h002E, 8'h29, 8'hFF);
      rd(16'h002F, d);
      chk("R11 unimplemented read", 32'(d), 0);
      chk("R11 neighbours untouched", {ser1_irq, ser2_irq}, 32'h43);
      wr(16'h002E, 8'h22);
      rd(16'h002F, d);
      chk("R11 index 0x22 read", 32'(d), 0);
   endtask

   task automatic t_other_addr;
      logic [7:0] d;
      wr(16'h002E, 8'h02);
      wr(16'h0030, 8'h80);
      wr(16'h102F, 8'h80);
      chk("R12 foreign write", 32'(ser_pwr), 32'h1);
      rd(16'h0030, d);
      chk("R12 foreign read", 32'(d), 0);
      wr(16'h012E, 8'h24);
      rd(16'h002F, d);
      chk("R12 index unchanged", 32'(d), 32'h08);
   endtask

   task automatic t_relock;
      logic [7:0] d;
      wr(16'h002E, 8'hAA);
      rd(16'h002F, d);
      chk("R3 relocked read", 32'(d), 0);
      wr(16'h002F, 8'h80);
      chk("R3 relocked write ignored", 32'(ser_pwr), 32'h1);
      wr(16'h002E, 8'h55);
      rd(16'h002F, d);
      chk("R3 unlocked again", 32'(d), 32'h08);
   endtask

   task automatic t_straps;
      logic [15:0] ports [4] = '{16'h002E, 16'h004E, 16'h162E, 16'h164E};
      logic [7:0]  d;
      for (int s = 1; s < 4; s++) begin
         do_reset(2'(s));
         chk("R1 cleared by reset", 32'(ser_pwr), 0);
         wr(16'h002E, 8'h55);
         set_reg(16'h002E, 8'h02, 8'h80);
         chk("R2 old port dead", 32'(ser_pwr), 0);
         wr(ports[s], 8'h55);
         set_reg(ports[s], 8'h02, 8'h80);
         chk("R2 strap port", 32'(ser_pwr), 32'h2);
         rd(ports[s] + 16'd1, d);
         chk("R2 strap data port", 32'(d), 32'h80);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset_state();
      t_locked_ignore();
      t_power();
      t_serial();
      t_runtime();
      t_gpio();
      t_unimpl();
      t_other_addr();
      t_relock();
      t_straps();
      repeat (2) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule